// File: doc/BRIEF.md
# Six-Button Gamepad Port Read Multiplexer

This block produces the byte a processor sees when it reads one controller data port. It combines three things: the port's output data register, the port's direction register, and a group of active-high button states chosen by the select line. The select line is bit 6 of the data register. A three-button pad shows two groups, picked by the level of the select line alone.

When the six-button mode input is set, the block also tracks a hidden phase. The phase counts rising edges of the select line and stops at three. Phases two and three change the groups that are shown, so software can read the extra buttons (Mode, X, Y, Z) and an identification nibble of all ones. The phase returns to zero after a programmable quiet time with no rising edge. At the default setting this is about 1.5 ms with a 125 MHz clock.

The read value is captured into an output register on each read strobe. It holds its value between strobes.

Top module: `pad_port_mux`

## Requirements
- R1: While reset is asserted, `rd_data` is set to 0 and the phase is set to 0. Reset also records the select line as high, so the first rising edge counted is one that follows a low level seen after reset.
- R2: `rd_data` changes only at a clock edge where `rd_stb` is 1. On other cycles it holds its value, whatever the other inputs do.
- R3: Bit 7 of `rd_data` is always `data_reg[7]`. Bit 6 is `data_reg[6]` when `dir_reg[6]` is 1, and 0 otherwise. For bits 5:0, the value is the OR of the button group bit and `data_reg` bit, where the `data_reg` bit is masked by the matching `dir_reg` bit (1 = output).
- R4: Button word bit positions are: 0 Up, 1 Down, 2 Left, 3 Right, 4 B, 5 C, 6 A, 7 Start, 8 Z, 9 Y, 10 X, 11 Mode. A pressed button reads as 0. In a normal case with the select line high, group bits 5:0 are C, B, Right, Left, Down, Up.
- R5: In a normal case with the select line low, group bits 5:4 are Start and A, bits 3:2 are 0, and bits 1:0 are Down and Up.
- R6: The phase rises by one at each clock edge where `data_reg[6]` is 1 and was 0 at the previous edge. The phase stays at 3 once it reaches 3.
- R7: In six-button mode, at phase 2 with the select line low, group bits 5:4 are Start and A and bits 3:0 are 0.
- R8: In six-button mode, at phase 3 with the select line high, group bits 5:4 are C and B and bits 3:0 are Mode, X, Y, Z.
- R9: In six-button mode, at phase 3 with the select line low, group bits 5:4 are Start and A and bits 3:0 are all ones.
- R10: With `six_btn_en` at 0, only the cases of R4 and R5 apply, at any phase.
- R11: After `TIMEOUT_CYCLES` clock edges in a row with no rising edge of the select line, the phase returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_stb | input | 1 | Captures a new read value at this edge |
| buttons | input | 12 | Button states, 1 = pressed |
| data_reg | input | 8 | Port output data register; bit 6 is the select line |
| dir_reg | input | 8 | Port direction register, 1 = output |
| six_btn_en | input | 1 | Enables six-button phase behaviour |
| rd_data | output | 8 | Registered port read value |

## Verification
The bench builds the block with `TIMEOUT_CYCLES` set to 64 instead of the millisecond-scale default. With that value, a full toggle sequence fits well inside the quiet window, and the phase reset is reached after a wait of only about a hundred cycles. The port width and button count stay at their defaults, because the group layout fixes them.

// File: rtl/pad_mux_pkg.sv
package pad_mux_pkg;

  localparam int BTN_W  = 12;
  localparam int PORT_W = 8;
  localparam int GRP_W  = 6;
  localparam int SEL_BIT = 6;

  // bit positions within the button word
  localparam int B_UP    = 0;
  localparam int B_DOWN  = 1;
  localparam int B_LEFT  = 2;
  localparam int B_RIGHT = 3;
  localparam int B_B     = 4;
  localparam int B_C     = 5;
  localparam int B_A     = 6;
  localparam int B_START = 7;
  localparam int B_Z     = 8;
  localparam int B_Y     = 9;
  localparam int B_X     = 10;
  localparam int B_MODE  = 11;

  typedef enum logic [1:0] {
    PH_ZERO  = 2'd0,
    PH_ONE   = 2'd1,
    PH_TWO   = 2'd2,
    PH_THREE = 2'd3
  } pad_phase_t;

endpackage

// File: rtl/pad_sel_phase_tracker.sv
module pad_sel_phase_tracker
  import pad_mux_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 187500,
  localparam int IDLE_W = $clog2(TIMEOUT_CYCLES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_in,
  output pad_phase_t        phase,
  output logic              sel_prev,
  output logic [IDLE_W-1:0] idle_cnt
);

  localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(TIMEOUT_CYCLES - 1);

  logic sel_rise;
  assign sel_rise = sel_in & ~sel_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_prev <= 1'b1;
      phase    <= PH_ZERO;
      idle_cnt <= '0;
    end else begin
      sel_prev <= sel_in;
      if (sel_rise) begin
        idle_cnt <= '0;
        if (phase != PH_THREE) phase <= pad_phase_t'(phase + 2'd1);
      end else if (idle_cnt == IDLE_LAST) begin
        phase <= PH_ZERO;
      end else begin
        idle_cnt <= idle_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pad_group_select.sv
module pad_group_select
  import pad_mux_pkg::*;
(
  input  logic [BTN_W-1:0] btn_n,
  input  logic             sel,
  input  pad_phase_t       phase,
  input  logic             six_en,
  output logic [GRP_W-1:0] grp
);

  logic [GRP_W-1:0] grp_hi;
  logic [GRP_W-1:0] grp_lo;
  logic [GRP_W-1:0] grp_ext;
  logic [GRP_W-1:0] grp_null;
  logic [GRP_W-1:0] grp_id;

  assign grp_hi   = {btn_n[B_C], btn_n[B_B], btn_n[B_RIGHT], btn_n[B_LEFT],
                     btn_n[B_DOWN], btn_n[B_UP]};
  assign grp_lo   = {btn_n[B_START], btn_n[B_A], 2'b00,
                     btn_n[B_DOWN], btn_n[B_UP]};
  assign grp_ext  = {btn_n[B_C], btn_n[B_B], btn_n[B_MODE], btn_n[B_X],
                     btn_n[B_Y], btn_n[B_Z]};
  assign grp_null = {btn_n[B_START], btn_n[B_A], 4'b0000};
  assign grp_id   = {btn_n[B_START], btn_n[B_A], 4'b1111};

  always_comb begin
    grp = sel ? grp_hi : grp_lo;
    if (six_en) begin
      if (phase == PH_TWO && !sel)   grp = grp_null;
      if (phase == PH_THREE &&  sel) grp = grp_ext;
      if (phase == PH_THREE && !sel) grp = grp_id;
    end
  end

endmodule

// File: rtl/pad_dir_merge.sv
module pad_dir_merge #(
  parameter int PORT_W = 8,
  parameter int GRP_W  = 6
) (
  input  logic [PORT_W-1:0] data_reg,
  input  logic [PORT_W-1:0] dir_reg,
  input  logic [GRP_W-1:0]  grp,
  output logic [PORT_W-1:0] merged
);

  for (genvar i = 0; i < PORT_W; i++) begin : g_bit
    logic drive;
    if (i == PORT_W - 1) begin : g_top
      assign drive = 1'b1;
    end else begin : g_dir
      assign drive = dir_reg[i];
    end
    if (i < GRP_W) begin : g_grp
      assign merged[i] = (data_reg[i] & drive) | grp[i];
    end else begin : g_reg
      assign merged[i] = data_reg[i] & drive;
    end
  end

endmodule

// File: rtl/pad_port_mux.sv
module pad_port_mux
  import pad_mux_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 187500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_stb,
  input  logic [BTN_W-1:0]  buttons,
  input  logic [PORT_W-1:0] data_reg,
  input  logic [PORT_W-1:0] dir_reg,
  input  logic              six_btn_en,
  output logic [PORT_W-1:0] rd_data
);

  localparam int IDLE_W = $clog2(TIMEOUT_CYCLES);

  logic [BTN_W-1:0]  btn_n;
  pad_phase_t        phase_w;
  logic              sel_prev_w;
  logic [IDLE_W-1:0] idle_w;
  logic [GRP_W-1:0]  grp_w;
  logic [PORT_W-1:0] merged_w;

  assign btn_n = ~buttons;

  pad_sel_phase_tracker #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) trk_i (
    .clk      (clk),
    .rst      (rst),
    .sel_in   (data_reg[SEL_BIT]),
    .phase    (phase_w),
    .sel_prev (sel_prev_w),
    .idle_cnt (idle_w)
  );

  pad_group_select sel_i (
    .btn_n  (btn_n),
    .sel    (data_reg[SEL_BIT]),
    .phase  (phase_w),
    .six_en (six_btn_en),
    .grp    (grp_w)
  );

  pad_dir_merge #(.PORT_W(PORT_W), .GRP_W(GRP_W)) mrg_i (
    .data_reg (data_reg),
    .dir_reg  (dir_reg),
    .grp      (grp_w),
    .merged   (merged_w)
  );

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (rd_stb) rd_data <= merged_w;
  end

endmodule

// File: rtl/pad_port_mux_chk.sv
module pad_port_mux_chk #(
  parameter int TIMEOUT_CYCLES = 187500,
  localparam int IDLE_W = $clog2(TIMEOUT_CYCLES)
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_stb,
  input logic [7:0]        data_reg,
  input logic              six_btn_en,
  input logic [7:0]        rd_data,
  input logic [1:0]        phase,
  input logic              sel_prev,
  input logic [IDLE_W-1:0] idle_cnt
);

  logic rise;
  assign rise = data_reg[6] & ~sel_prev;

  // R1: phase is zero on the first cycle after reset
  p_phase_zero_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (phase == 2'd0 && rd_data == 8'h00));

  // R2: no strobe, no change
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> $stable(rd_data));

  // R3: bit 7 always follows the data register
  p_top_bit_r3: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> rd_data[7] == $past(data_reg[7]));

  // R6: step by one on a rising edge below the limit
  p_phase_step_r6: assert property (@(posedge clk) disable iff (rst)
    (rise && phase != 2'd3) |=> phase == $past(phase) + 2'd1);

  // R6: saturation at three
  p_phase_sat_r6: assert property (@(posedge clk) disable iff (rst)
    (rise && phase == 2'd3) |=> phase == 2'd3);

  // R9: identification nibble
  p_id_nibble_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && six_btn_en && phase == 2'd3 && !data_reg[6])
      |=> rd_data[3:0] == 4'hF);

  // R11: quiet window expiry clears the phase
  p_timeout_r11: assert property (@(posedge clk) disable iff (rst)
    (!rise && idle_cnt == IDLE_W'(TIMEOUT_CYCLES - 1)) |=> phase == 2'd0);

endmodule

bind pad_port_mux pad_port_mux_chk #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .rd_stb     (rd_stb),
  .data_reg   (data_reg),
  .six_btn_en (six_btn_en),
  .rd_data    (rd_data),
  .phase      (phase_w),
  .sel_prev   (sel_prev_w),
  .idle_cnt   (idle_w)
);

// File: tb/pad_port_mux_tb.sv
module pad_port_mux_tb_top;

  localparam int TO = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_stb = 1'b0;
  logic [11:0] buttons = '0;
  logic [7:0]  data_reg = '0;
  logic [7:0]  dir_reg = '0;
  logic        six_btn_en = 1'b0;
  logic [7:0]  rd_data;

  int n_chk = 0;
  int n_fail = 0;
  int m_phase = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pad_port_mux #(.TIMEOUT_CYCLES(TO)) dut_i (
    .clk(clk), .rst(rst), .rd_stb(rd_stb), .buttons(buttons),
    .data_reg(data_reg), .dir_reg(dir_reg), .six_btn_en(six_btn_en),
    .rd_data(rd_data)
  );

  function automatic logic [7:0] model(input logic [11:0] b, input logic [7:0] d,
                                       input logic [7:0] dr, input logic six,
                                       input int ph);
    logic [11:0] n;
    logic [5:0]  g;
    n = ~b;
    if (six && ph == 2 && !d[6])      g = {n[7], n[6], 4'b0000};
    else if (six && ph == 3 && d[6])  g = {n[5], n[4], n[11], n[10], n[9], n[8]};
    else if (six && ph == 3)          g = {n[7], n[6], 4'b1111};
    else if (d[6])                    g = n[5:0];
    else                              g = {n[7], n[6], 2'b00, n[1], n[0]};
    return (d & (dr | 8'h80)) | {2'b00, g};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic do_read(output logic [7:0] v);
    @(negedge clk) rd_stb = 1'b1;
    @(negedge clk) rd_stb = 1'b0;
    v = rd_data;
  endtask

  task automatic set_sel(input logic v);
    @(negedge clk);
    if (v && !data_reg[6] && m_phase < 3) m_phase++;
    data_reg[6] = v;
    @(negedge clk);
  endtask

  task automatic quiet();
    repeat (TO + 16) @(negedge clk);
    m_phase = 0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    data_reg = 8'h40;
    repeat (3) @(negedge clk);
    chk("R1 reset value", rd_data, 8'h00);
    rst = 1'b0;
    m_phase = 0;
  endtask

  task automatic t_normal();
    logic [7:0] v;
    logic [11:0] pats [3] = '{12'h000, 12'hFFF, 12'hA5C};
    six_btn_en = 1'b0;
    dir_reg = 8'h40;
    foreach (pats[k]) begin
      buttons = pats[k];
      set_sel(1'b1);
      do_read(v);
      chk("R4 select high", v, model(buttons, data_reg, dir_reg, 1'b0, 0));
      set_sel(1'b0);
      do_read(v);
      chk("R5 select low", v, model(buttons, data_reg, dir_reg, 1'b0, 0));
    end
    buttons = 12'h0C3;
    set_sel(1'b0);
    do_read(v);
    chk("R5 select low start a down up", v, 8'h00);
  endtask

  task automatic t_dir();
    logic [7:0] v;
    six_btn_en = 1'b0;
    buttons = 12'h03F;
    dir_reg = 8'h0F;
    @(negedge clk) data_reg = 8'hFF;
    do_read(v);
    chk("R3 output bits merged", v, 8'h8F);
    buttons = 12'h000;
    dir_reg = 8'h00;
    @(negedge clk) data_reg = 8'h40;
    do_read(v);
    chk("R3 input select bit reads 0", v, 8'h3F);
    data_reg = 8'h00;
    quiet();
  endtask

  task automatic t_six(input logic six, input logic [11:0] pat);
    logic [7:0] v;
    string tg;
    quiet();
    six_btn_en = six;
    dir_reg = 8'h40;
    buttons = pat;
    set_sel(1'b0);
    for (int step = 0; step < 4; step++) begin
      set_sel(1'b1);
      do_read(v);
      tg = !six ? "R10 high" : (m_phase == 3 ? "R8 ext group" : "R6 R4 early phase high");
      chk(tg, v, model(buttons, data_reg, dir_reg, six, m_phase));
      set_sel(1'b0);
      do_read(v);
      tg = !six ? "R10 low" : (m_phase == 3 ? "R9 id nibble" :
                               (m_phase == 2 ? "R7 null nibble" : "R5 early phase low"));
      chk(tg, v, model(buttons, data_reg, dir_reg, six, m_phase));
    end
  endtask

  task automatic t_sat_fixed();
    logic [7:0] v;
    quiet();
    six_btn_en = 1'b1;
    dir_reg = 8'h40;
    buttons = 12'hF00;
    set_sel(1'b0);
    repeat (5) begin set_sel(1'b1); set_sel(1'b0); end
    set_sel(1'b1);
    do_read(v);
    chk("R6 R8 saturated ext", v, 8'h70);
    set_sel(1'b0);
    do_read(v);
    chk("R9 saturated id", v, 8'h3F);
  endtask

  task automatic t_timeout();
    logic [7:0] v;
    quiet();
    six_btn_en = 1'b1;
    dir_reg = 8'h40;
    buttons = 12'h000;
    set_sel(1'b0);
    repeat (3) begin set_sel(1'b1); set_sel(1'b0); end
    repeat (30) @(negedge clk);
    do_read(v);
    chk("R11 phase kept inside window", v, 8'h3F);
    repeat (TO + 20) @(negedge clk);
    do_read(v);
    chk("R11 phase cleared after window", v, 8'h33);
  endtask

  task automatic t_hold();
    logic [7:0] v;
    six_btn_en = 1'b0;
    dir_reg = 8'h40;
    buttons = 12'h000;
    set_sel(1'b1);
    do_read(v);
    chk("R2 baseline", v, 8'h7F);
    @(negedge clk);
    buttons = 12'hFFF;
    data_reg = 8'h00;
    dir_reg = 8'hFF;
    repeat (5) @(negedge clk);
    chk("R2 held without strobe", rd_data, 8'h7F);
  endtask

  initial begin
    t_reset();
    t_normal();
    t_dir();
    t_six(1'b1, 12'h000);
    t_six(1'b1, 12'h5A5);
    t_six(1'b0, 12'h3C6);
    t_sat_fixed();
    t_timeout();
    t_hold();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule